// File: doc/BRIEF.md
# Colored Button Code Lock

This controller opens a lock only when a fixed key sequence arrives. A start button first arms the lock. After that, four colored presses must follow in the order red, blue, green, red. Each colored press arrives as a one-cycle pulse on the shared "some color pressed" line, together with the line for its own color. Any press that does not match the next expected color sends the controller back to idle. This includes a wrong color and a press with more than one color line high.

The controller is a Moore machine. Its state register holds six states in a 3-bit binary count, with idle at zero. The unlock output depends only on that register. It is high for exactly one clock, in the cycle that follows the fourth correct press. The controller then returns to idle on its own. A new attempt always needs a fresh start press.

Top module: `color_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller enters idle, and `unlock` is 0 in the cycle that follows.
- R2: In idle, a colored press (`any_btn` high, with any color lines) is ignored, and the controller stays idle until `start_btn` is high at an edge.
- R3: `start_btn` high at an edge while idle arms the controller. The next expected color is red.
- R4: While armed or part-way through the code, a cycle with `any_btn` low keeps the current state, even if some color lines are high.
- R5: A press advances the code only when `any_btn` is high, the expected color line is high, and the other two color lines are low. The expected colors are red, then blue, then green, then red.
- R6: A press with `any_btn` high that does not meet R5 returns the controller to idle. This covers a wrong single color, two or three colors at once, and no color line at all. After such a press, further colored presses have no effect until a new start press.
- R7: `unlock` is 1 in the single cycle after the edge that samples the fourth correct press. It is 0 in every other cycle.
- R8: From the unlocked state the controller returns to idle at the next edge, whatever its inputs. A start press in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start button level |
| red_btn | input | 1 | Red color line |
| green_btn | input | 1 | Green color line |
| blue_btn | input | 1 | Blue color line |
| any_btn | input | 1 | High for one cycle when any colored button is pressed |
| unlock | output | 1 | One-cycle unlock pulse |

## Verification
Two things can coincide in one cycle: the final unlock pulse, and a new press or start request that the controller must discard as it falls back to idle. The bench provokes this by driving `start_btn`, or a correct red press, during the `unlock` cycle. It then feeds a code sequence with no new start. That pulse must end after one cycle, and the following presses must not unlock. A second overlap is a press that carries the right color together with a second color line. The bench judges it by checking that the controller aborts rather than advances.

// File: rtl/color_lock_pkg.sv
package color_lock_pkg;
   localparam int STATE_W    = 3;
   localparam int NUM_COLORS = 3;

   // color line index inside the packed color vector
   localparam int COL_RED   = 0;
   localparam int COL_GREEN = 1;
   localparam int COL_BLUE  = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_GOT_R = 3'd2,
      ST_GOT_B = 3'd3,
      ST_GOT_G = 3'd4,
      ST_OPEN  = 3'd5
   } lock_state_t;

   // color expected while in a collecting state
   function automatic int expected_color(input lock_state_t st);
      case (st)
         ST_ARMED: return COL_RED;
         ST_GOT_R: return COL_BLUE;
         ST_GOT_B: return COL_GREEN;
         default:  return COL_RED;
      endcase
   endfunction

   function automatic lock_state_t advance_of(input lock_state_t st);
      case (st)
         ST_ARMED: return ST_GOT_R;
         ST_GOT_R: return ST_GOT_B;
         ST_GOT_B: return ST_GOT_G;
         ST_GOT_G: return ST_OPEN;
         default:  return ST_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/cl_press_decode.sv
module cl_press_decode #(
   parameter int NUM_COLORS = 3
) (
   input  logic                  any_btn,
   input  logic [NUM_COLORS-1:0] colors,
   output logic [NUM_COLORS-1:0] exact_hit,
   output logic                  press_seen
);
   if (NUM_COLORS < 2) begin : g_bad_width
      $error("cl_press_decode needs at least two colors");
   end

   // a color counts only when it is the sole color line raised with any_btn
   for (genvar i = 0; i < NUM_COLORS; i++) begin : g_hit
      localparam logic [NUM_COLORS-1:0] OTHERS = ~(NUM_COLORS'(1) << i);
      assign exact_hit[i] = any_btn & colors[i] & ~|(colors & OTHERS);
   end

   assign press_seen = any_btn;
endmodule

// File: rtl/cl_next_state.sv
module cl_next_state
   import color_lock_pkg::*;
#(
   parameter int NUM_COLORS = color_lock_pkg::NUM_COLORS
) (
   input  lock_state_t           cur,
   input  logic                  start_btn,
   input  logic                  press_seen,
   input  logic [NUM_COLORS-1:0] exact_hit,
   output lock_state_t           nxt
);
   always_comb begin
      nxt = ST_IDLE;
      case (cur)
         ST_IDLE:  nxt = start_btn ? ST_ARMED : ST_IDLE;
         ST_ARMED, ST_GOT_R, ST_GOT_B, ST_GOT_G: begin
            if (!press_seen)
               nxt = cur;
            else if (exact_hit[expected_color(cur)])
               nxt = advance_of(cur);
            else
               nxt = ST_IDLE;
         end
         ST_OPEN:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/color_lock.sv
module color_lock
   import color_lock_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start_btn,
   input  logic red_btn,
   input  logic green_btn,
   input  logic blue_btn,
   input  logic any_btn,
   output logic unlock
);
   if (STATE_W < 3) begin : g_bad_state_w
      $error("color_lock needs a state register of at least 3 bits");
   end

   logic [NUM_COLORS-1:0] colors;
   logic [NUM_COLORS-1:0] exact_hit;
   logic                  press_seen;
   lock_state_t           state_q;
   lock_state_t           state_d;

   always_comb begin
      colors            = '0;
      colors[COL_RED]   = red_btn;
      colors[COL_GREEN] = green_btn;
      colors[COL_BLUE]  = blue_btn;
   end

   cl_press_decode #(.NUM_COLORS(NUM_COLORS)) u_decode (
      .any_btn   (any_btn),
      .colors    (colors),
      .exact_hit (exact_hit),
      .press_seen(press_seen)
   );

   cl_next_state #(.NUM_COLORS(NUM_COLORS)) u_next (
      .cur       (state_q),
      .start_btn (start_btn),
      .press_seen(press_seen),
      .exact_hit (exact_hit),
      .nxt       (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign unlock = (state_q == ST_OPEN);
endmodule

// File: rtl/color_lock_chk.sv
module color_lock_chk (
   input logic       clk,
   input logic       rst,
   input logic       start_btn,
   input logic       red_btn,
   input logic       green_btn,
   input logic       blue_btn,
   input logic       any_btn,
   input logic       unlock,
   input logic [2:0] state
);
   logic collecting;
   assign collecting = (state >= 3'd1) && (state <= 3'd4);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> !unlock);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state == 3'd0 && !start_btn) |=> state == 3'd0);

   // R4
   no_press_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (collecting && !any_btn) |=> $stable(state));

   // R6
   multi_abort_chk: assert property (@(posedge clk) disable iff (rst)
      (collecting && any_btn && $countones({red_btn, green_btn, blue_btn}) != 1)
      |=> state == 3'd0);

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      unlock |=> !unlock);

   // R7
   pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(unlock) |-> $past(state) == 3'd4);

   // R8
   open_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
      unlock |=> state == 3'd0);
endmodule

bind color_lock color_lock_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .start_btn(start_btn),
   .red_btn  (red_btn),
   .green_btn(green_btn),
   .blue_btn (blue_btn),
   .any_btn  (any_btn),
   .unlock   (unlock),
   .state    (state_q)
);

// File: tb/test_color_lock.sv
module test_color_lock;
   logic clk = 0;
   logic rst, s, r, g, b, a;
   logic unlock;
   int   checks = 0, errors = 0;
   int   mst = 0;   // bench model: 0 idle,1 armed,2..4 partial,5 open
   bit   done = 0;

   always #5 clk = ~clk;

   color_lock i_color_lock (
      .clk(clk), .rst(rst), .start_btn(s), .red_btn(r), .green_btn(g),
      .blue_btn(b), .any_btn(a), .unlock(unlock)
   );

   // expected next state from the requirements
   function automatic int model_next(int st, bit ss, bit rr, bit gg, bit bb, bit aa);
      bit exact;
      int want;
      if (st == 0) return ss ? 1 : 0;
      if (st == 5) return 0;
      if (!aa) return st;
      want = (st == 2) ? 2 : (st == 3) ? 1 : 0; // 0 red,1 green,2 blue
      exact = (want == 0) ? (rr && !gg && !bb) :
              (want == 1) ? (gg && !rr && !bb) : (bb && !rr && !gg);
      return exact ? st + 1 : 0;
   endfunction

   task automatic check(bit act, bit exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s unlock=%0b expected=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step(bit ss, bit rr, bit gg, bit bb, bit aa, string req);
      @(negedge clk);
      s = ss; r = rr; g = gg; b = bb; a = aa;
      @(posedge clk);
      mst = rst ? 0 : model_next(mst, ss, rr, gg, bb, aa);
      #1;
      check(unlock, mst == 5, req);
   endtask

   task automatic code(string req);
      step(0, 1, 0, 0, 1, req);
      step(0, 0, 0, 1, 1, req);
      step(0, 0, 1, 0, 1, req);
      step(0, 1, 0, 0, 1, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1c0d_e5ed));
      rst = 1; s = 0; r = 0; g = 0; b = 0; a = 0;
      @(posedge clk); @(posedge clk); #1;
      check(unlock, 0, "R1 reset");
      @(negedge clk); rst = 0;

      // R3 R5 R7: plain correct code, pulse then drop
      step(1, 0, 0, 0, 0, "R3 arm");
      code("R5 R7 code");
      step(0, 0, 0, 0, 0, "R7 pulse one cycle");

      // R2: colored presses while idle do nothing
      code("R2 idle press ignored");

      // R4: color lines without any_btn hold the state
      step(1, 0, 0, 0, 0, "R3 arm");
      step(0, 1, 0, 0, 1, "R5 red");
      step(0, 1, 1, 1, 0, "R4 lines without any");
      step(0, 0, 0, 1, 1, "R5 blue");
      step(0, 0, 0, 0, 0, "R4 idle cycle");
      step(0, 0, 1, 0, 1, "R5 green");
      step(0, 1, 0, 0, 1, "R7 open");

      // R8: start and a press during the open cycle are discarded
      step(1, 1, 0, 0, 1, "R8 open to idle");
      code("R8 start in open not taken");

      // R6: wrong color aborts, sequence continued without start fails
      step(1, 0, 0, 0, 0, "R3 arm");
      step(0, 1, 0, 0, 1, "R5 red");
      step(0, 0, 1, 0, 1, "R6 wrong color");
      step(0, 0, 1, 0, 1, "R6 after abort");
      step(0, 1, 0, 0, 1, "R6 after abort");

      // R6: right color plus another line aborts
      step(1, 0, 0, 0, 0, "R3 arm");
      step(0, 1, 0, 1, 1, "R6 two colors");
      code("R6 no unlock after multi");
      // R6: any_btn with no color aborts
      step(1, 0, 0, 0, 0, "R3 arm");
      step(0, 0, 0, 0, 1, "R6 empty press");
      step(0, 1, 0, 0, 1, "R6 empty press");

      // random mix, biased toward the correct code
      for (int n = 0; n < 4000; n++) begin
         int pick = $urandom_range(0, 9);
         bit ss = 0, rr = 0, gg = 0, bb = 0, aa = 0;
         if (pick < 6) begin
            if (mst == 0) ss = 1;
            else begin
               aa = 1;
               if (mst == 1 || mst == 4) rr = 1;
               else if (mst == 2) bb = 1;
               else gg = 1;
            end
         end else begin
            ss = 1'($urandom); rr = 1'($urandom); gg = 1'($urandom);
            bb = 1'($urandom); aa = 1'($urandom);
         end
         step(ss, rr, gg, bb, aa, "R5 R6 R7 random");
      end

      // R1: reset mid-code
      step(1, 0, 0, 0, 0, "R3 arm");
      step(0, 1, 0, 0, 1, "R5 red");
      @(negedge clk); rst = 1;
      step(0, 0, 0, 1, 1, "R1 reset mid code");
      @(negedge clk); rst = 0;
      step(0, 0, 1, 0, 1, "R1 code lost");
      step(0, 1, 0, 0, 1, "R1 code lost");

      finish_run();
   end
endmodule